// File: doc/BRIEF.md
# Two-Wire Memory Read Engine

This block is the target side of a two-wire serial bus sitting in front of a 16K x 8 memory array. It watches oversampled copies of the clock and data lines. It recognises bus start, stop and repeated-start conditions. It accepts a device-type match and, in write mode, takes two word-address bytes that load an internal address pointer. In read mode it streams bytes from the array, most significant bit first. The only thing it drives onto the bus is an open-drain pull-down enable for the data line.

Three read forms share one post-increment pointer. A current-address read starts from wherever the pointer sits. A random read first does a dummy write that carries two word-address bytes, then a repeated start and a read-mode address byte. A sequential read keeps going for as long as the controller acknowledges each byte. On the ninth clock after each transmitted byte, the controller's acknowledge decides whether the transfer continues. A not-acknowledge ends the transfer.

Array bytes are fetched over a valid/ready request channel followed by a response strobe. A request holds its valid and address until the memory accepts it with ready. Ready may be held low for any number of cycles. The block issues at most one outstanding request and never back-pressures the response. It does not stretch the bus clock, so the response must arrive before the bus clock falls at the end of the acknowledge bit that precedes the byte.

Top module: `tw_mem_reader`

## Requirements
- R1: A falling data line while the clock is high is a start condition, and a rising data line while the clock is high is a stop condition. A start in any state, including partway through a transfer, begins a new address byte. A stop returns the block to idle, where bytes clocked without a start are not acknowledged.
- R2: An address byte whose upper four bits are 1010 is acknowledged: the block holds the data line low through the ninth clock. Bits 3 to 1 are ignored and bit 0 selects the direction, with 1 meaning read. Any other upper nibble gets no acknowledge, starts no memory request, and leaves the block idle until the next start.
- R3: In write mode, the two bytes after the address byte are the word address, high byte first. Each is acknowledged, and together they load the pointer with {high[5:0], low}. Bits 7 and 6 of the high byte are ignored.
- R4: Data bytes that follow the two word-address bytes in a write are not acknowledged and leave the pointer unchanged.
- R5: After acknowledging a read-mode address byte, the block sends the byte at the pointer, most significant bit first. Every fetched byte advances the pointer by one, so a read with no new address returns location n+1 after location n was read.
- R6: If the data line is low on the ninth clock after a sent byte, the next byte is sent. If it is high, the block releases the data line and sends nothing more until the next start.
- R7: The pointer wraps from 3FFFh to 0000h during sequential reads.
- R8: The pull-down enable changes only while the bus clock is low.
- R9: A memory request holds its valid and address steady until ready is seen. Exactly one request is accepted for each byte sent, and none is issued while another is pending.
- R10: After reset the data line is released and no memory request is valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, fast enough to oversample the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Sampled bus clock line |
| sda_in | input | 1 | Sampled bus data line (wired-AND of all drivers) |
| sda_pull | output | 1 | When 1, pull the bus data line low |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts the request this cycle |
| mem_req_addr | output | ADDR_W | Array location to read |
| mem_rsp_valid | input | 1 | Read data valid strobe |
| mem_rsp_data | input | 8 | Read data |

## Verification
The bench aims at the pointer rules. A current-address read after a random read must return n+1, a read across 3FFFh must return location 0000h, and the high address byte carries junk in its top two bits. A design that incremented too late or too often would return a stale or skipped byte, and one that decoded all 16 address bits would read the wrong location. It also checks the ninth-clock rules: a master acknowledge must produce another byte, while a not-acknowledge must leave the line released even when the controller keeps clocking. It checks refusal cases as well: a foreign device type, extra write data bytes, and bytes clocked after a stop. A design that acknowledged any of these would be seen pulling the line low on the ninth clock or issuing extra memory requests. The memory model throttles ready, so a request that dropped or changed its address before acceptance would show up as a wrong byte.

// File: rtl/tw_mem_reader_pkg.sv
package tw_mem_reader_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_ACK_DEV,
    ST_AHI,
    ST_ACK_HI,
    ST_ALO,
    ST_ACK_LO,
    ST_TX,
    ST_MACK,
    ST_NEXT
  } tw_state_t;

  localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/tw_bus_sense.sv
module tw_bus_sense #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [SYNC_STAGES-1:0] scl_sr, sda_sr;
  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sr <= '1;
      sda_sr <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_sr <= {scl_sr[SYNC_STAGES-2:0], scl_in};
      sda_sr <= {sda_sr[SYNC_STAGES-2:0], sda_in};
      scl_p  <= scl_sr[SYNC_STAGES-1];
      sda_p  <= sda_sr[SYNC_STAGES-1];
    end
  end

  assign scl_s     = scl_sr[SYNC_STAGES-1];
  assign sda_s     = sda_sr[SYNC_STAGES-1];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/tw_addr_ptr.sv
module tw_addr_ptr #(
  parameter int unsigned ADDR_W = 14,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              fetch,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data,
  output logic [DATA_W-1:0] tx_byte
);

  logic [ADDR_W-1:0] ptr;
  logic              accept;

  assign accept       = mem_req_valid & mem_req_ready;
  assign mem_req_addr = ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr           <= '0;
      mem_req_valid <= 1'b0;
      tx_byte       <= '1;
    end else begin
      if (load) begin
        ptr <= load_val;
      end else if (accept) begin
        ptr <= ptr + 1'b1;
      end
      if (accept) begin
        mem_req_valid <= 1'b0;
      end else if (fetch) begin
        mem_req_valid <= 1'b1;
      end
      if (mem_rsp_valid) begin
        tx_byte <= mem_rsp_data;
      end
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))) // R9
    else $error("request dropped or changed before acceptance");

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    fetch |-> !mem_req_valid) // R9
    else $error("fetch issued while a request is pending");

  AST_NO_LOAD_DURING_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !mem_req_valid) // R3
    else $error("pointer load while request pending");

endmodule

// File: rtl/tw_mem_reader.sv
module tw_mem_reader
  import tw_mem_reader_pkg::*;
#(
  parameter int unsigned ADDR_W      = 14,
  parameter logic [3:0]  DEV_TYPE    = 4'b1010,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_pull,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [BYTE_W-1:0] mem_rsp_data
);

  localparam int unsigned HI_W = ADDR_W - BYTE_W;

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  tw_bus_sense #(.SYNC_STAGES(SYNC_STAGES)) u_sense (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_in    (scl_in),
    .sda_in    (sda_in),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  tw_state_t         st;
  logic [3:0]        cnt;
  logic [BYTE_W-1:0] rx_sh;
  logic [BYTE_W-1:0] tx_sh;
  logic [HI_W-1:0]   hi_q;
  logic              rw_q;
  logic              fetch, load;
  logic [ADDR_W-1:0] load_val;
  logic [BYTE_W-1:0] tx_byte;

  tw_addr_ptr #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) u_ptr (
    .clk           (clk),
    .rst_n         (rst_n),
    .load          (load),
    .load_val      (load_val),
    .fetch         (fetch),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .tx_byte       (tx_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      cnt      <= '0;
      rx_sh    <= '0;
      tx_sh    <= '0;
      hi_q     <= '0;
      rw_q     <= 1'b0;
      sda_pull <= 1'b0;
      fetch    <= 1'b0;
      load     <= 1'b0;
      load_val <= '0;
    end else begin
      fetch <= 1'b0;
      load  <= 1'b0;
      if (stop_det) begin
        st       <= ST_IDLE;
        sda_pull <= 1'b0;
      end else if (start_det) begin
        st       <= ST_DEV;
        cnt      <= '0;
        sda_pull <= 1'b0;
      end else begin
        unique case (st)
          ST_IDLE: ;
          ST_DEV, ST_AHI, ST_ALO: begin
            if (scl_rise && cnt < 4'd8) begin
              rx_sh <= {rx_sh[BYTE_W-2:0], sda_s};
              cnt   <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              if (st == ST_DEV) begin
                if (rx_sh[7:4] == DEV_TYPE) begin
                  st       <= ST_ACK_DEV;
                  rw_q     <= rx_sh[0];
                  sda_pull <= 1'b1;
                  fetch    <= rx_sh[0];
                end else begin
                  st <= ST_IDLE;
                end
              end else if (st == ST_AHI) begin
                hi_q     <= rx_sh[HI_W-1:0];
                st       <= ST_ACK_HI;
                sda_pull <= 1'b1;
              end else begin
                load     <= 1'b1;
                load_val <= {hi_q, rx_sh};
                st       <= ST_ACK_LO;
                sda_pull <= 1'b1;
              end
            end
          end
          ST_ACK_DEV: begin
            if (scl_fall) begin
              cnt <= '0;
              if (rw_q) begin
                st       <= ST_TX;
                tx_sh    <= tx_byte;
                sda_pull <= ~tx_byte[BYTE_W-1];
              end else begin
                st       <= ST_AHI;
                sda_pull <= 1'b0;
              end
            end
          end
          ST_ACK_HI: begin
            if (scl_fall) begin
              st       <= ST_ALO;
              cnt      <= '0;
              sda_pull <= 1'b0;
            end
          end
          ST_ACK_LO: begin
            if (scl_fall) begin
              st       <= ST_IDLE;
              sda_pull <= 1'b0;
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (cnt == 4'd7) begin
                st       <= ST_MACK;
                sda_pull <= 1'b0;
              end else begin
                cnt      <= cnt + 4'd1;
                tx_sh    <= {tx_sh[BYTE_W-2:0], 1'b0};
                sda_pull <= ~tx_sh[BYTE_W-2];
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) begin
              if (!sda_s) begin
                st    <= ST_NEXT;
                fetch <= 1'b1;
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          ST_NEXT: begin
            if (scl_fall) begin
              st       <= ST_TX;
              cnt      <= '0;
              tx_sh    <= tx_byte;
              sda_pull <= ~tx_byte[BYTE_W-1];
            end
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  AST_SDA_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_pull != $past(sda_pull)) |-> !scl_s) // R8
    else $error("data line changed while clock high");

  AST_START_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det && !stop_det) |=> (st == ST_DEV && cnt == 4'd0)) // R1
    else $error("start did not restart address reception");

  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (st == ST_IDLE && !sda_pull)) // R1
    else $error("stop did not return to idle");

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> !sda_pull) // R6
    else $error("line pulled while idle");

  AST_MACK_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_MACK) |-> !sda_pull) // R6
    else $error("line pulled during controller acknowledge");

endmodule

// File: tb/tw_mem_reader_tb.sv
module tw_mem_reader_tb_top;

  localparam int Q = 25;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl_drv = 1'b1;
  logic        sda_m = 1'b1;
  logic        sda_line;
  logic        sda_pull;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [13:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [7:0]  mem_rsp_data = '0;

  int n_chk = 0;
  int n_bad = 0;
  int acc_cnt = 0;
  int r8_viol = 0;
  bit done = 0;
  logic pull_prev = 1'b0;

  always #5 clk = ~clk;

  assign sda_line = sda_m & ~sda_pull;

  tw_mem_reader dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .scl_in        (scl_drv),
    .sda_in        (sda_line),
    .sda_pull      (sda_pull),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data)
  );

  function automatic logic [7:0] mf(input logic [13:0] a);
    return a[7:0] ^ {a[13:8], 2'b10};
  endfunction

  // memory model with throttled ready
  always @(posedge clk) begin
    if (rst_n && mem_req_valid && mem_req_ready) begin
      mem_rsp_valid <= 1'b1;
      mem_rsp_data  <= mf(mem_req_addr);
      acc_cnt       <= acc_cnt + 1;
    end else begin
      mem_rsp_valid <= 1'b0;
    end
    mem_req_ready <= ~mem_req_ready;
    if (rst_n && sda_pull != pull_prev && scl_drv) r8_viol <= r8_viol + 1;
    pull_prev <= sda_pull;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; waitc(Q);
    scl_drv = 1'b1; waitc(Q);
    sda_m = 1'b0; waitc(Q);
    scl_drv = 1'b0; waitc(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; waitc(Q);
    scl_drv = 1'b1; waitc(Q);
    sda_m = 1'b1; waitc(Q);
  endtask

  task automatic clock_bit(input logic b, output logic r);
    sda_m = b; waitc(Q);
    scl_drv = 1'b1; waitc(Q);
    r = sda_line; waitc(Q);
    scl_drv = 1'b0; waitc(Q);
  endtask

  task automatic wr_byte(input logic [7:0] d, output bit ack);
    logic r;
    for (int i = 7; i >= 0; i--) clock_bit(d[i], r);
    clock_bit(1'b1, r);
    ack = (r == 1'b0);
  endtask

  task automatic rd_byte(input bit give_ack, output logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      clock_bit(1'b1, r);
      d[i] = r;
    end
    clock_bit(~give_ack, r);
  endtask

  task automatic set_addr(input logic [7:0] hi, input logic [7:0] lo, input logic [7:0] dev);
    bit a;
    bus_start();
    wr_byte(dev, a);  chk(a, "R2 write-mode address ack", a, 1);
    wr_byte(hi, a);   chk(a, "R3 high word-address ack", a, 1);
    wr_byte(lo, a);   chk(a, "R3 low word-address ack", a, 1);
  endtask

  task automatic t_reset();
    chk(sda_pull == 1'b0, "R10 line released after reset", sda_pull, 0);
    chk(mem_req_valid == 1'b0, "R10 no request after reset", mem_req_valid, 0);
  endtask

  task automatic t_random_read();
    bit a; logic [7:0] d;
    set_addr(8'hD2, 8'h34, 8'hAE);      // upper bits 7:6 junk, chip bits ignored
    bus_start();                        // repeated start, R1
    wr_byte(8'hAF, a); chk(a, "R2 read-mode address ack", a, 1);
    rd_byte(0, d);     chk(d == mf(14'h1234), "R3 R5 random read byte", d, mf(14'h1234));
    bus_stop();
  endtask

  task automatic t_current_read();
    bit a; logic [7:0] d;
    bus_start();
    wr_byte(8'hA1, a); chk(a, "R2 current read ack", a, 1);
    rd_byte(0, d);     chk(d == mf(14'h1235), "R5 current read returns n+1", d, mf(14'h1235));
    bus_stop();
  endtask

  task automatic t_sequential();
    bit a; logic [7:0] d; int c0;
    set_addr(8'h01, 8'h00, 8'hA0);
    bus_start();
    c0 = acc_cnt;
    wr_byte(8'hA1, a);
    for (int i = 0; i < 4; i++) begin
      rd_byte(i != 3, d);
      chk(d == mf(14'h0100 + 14'(i)), "R6 sequential byte", d, mf(14'h0100 + 14'(i)));
    end
    bus_stop();
    chk(acc_cnt - c0 == 4, "R9 one request per byte", acc_cnt - c0, 4);
  endtask

  task automatic t_wrap();
    bit a; logic [7:0] d;
    set_addr(8'hFF, 8'hFE, 8'hA0);
    bus_start();
    wr_byte(8'hA1, a);
    rd_byte(1, d); chk(d == mf(14'h3FFE), "R7 byte at 3FFE", d, mf(14'h3FFE));
    rd_byte(1, d); chk(d == mf(14'h3FFF), "R7 byte at 3FFF", d, mf(14'h3FFF));
    rd_byte(0, d); chk(d == mf(14'h0000), "R7 wrap to 0000", d, mf(14'h0000));
    bus_stop();
  endtask

  task automatic t_bad_type();
    bit a; int c0;
    c0 = acc_cnt;
    bus_start();
    wr_byte(8'h51, a); chk(!a, "R2 foreign type not acked", a, 0);
    wr_byte(8'hA1, a); chk(!a, "R2 idle until next start", a, 0);
    bus_stop();
    chk(acc_cnt == c0, "R2 no request for foreign type", acc_cnt - c0, 0);
  endtask

  task automatic t_data_ignored();
    bit a; logic [7:0] d;
    set_addr(8'h0A, 8'h0B, 8'hA0);
    wr_byte(8'h55, a); chk(!a, "R4 write data byte not acked", a, 0);
    bus_stop();
    bus_start();
    wr_byte(8'hA1, a);
    rd_byte(0, d); chk(d == mf(14'h0A0B), "R4 pointer unchanged by data", d, mf(14'h0A0B));
    bus_stop();
  endtask

  task automatic t_nack_end();
    bit a; logic [7:0] d;
    bus_start();
    wr_byte(8'hA1, a);
    rd_byte(0, d); chk(d == mf(14'h0A0C), "R5 read after data test", d, mf(14'h0A0C));
    rd_byte(0, d); chk(d == 8'hFF, "R6 released after not-acknowledge", d, 8'hFF);
    bus_stop();
  endtask

  task automatic t_stop_idle();
    bit a;
    bus_start();
    wr_byte(8'hA0, a); chk(a, "R1 address ack before stop", a, 1);
    bus_stop();
    scl_drv = 1'b0; waitc(Q);
    wr_byte(8'hA1, a); chk(!a, "R1 no ack after stop without start", a, 0);
    sda_m = 1'b0; waitc(Q);
    bus_stop();
  endtask

  initial begin
    waitc(10);
    rst_n = 1'b1;
    waitc(5);
    t_reset();
    t_random_read();
    t_current_read();
    t_sequential();
    t_wrap();
    t_bad_type();
    t_data_ignored();
    t_nack_end();
    t_stop_idle();
    chk(r8_viol == 0, "R8 line changes only with clock low", r8_viol, 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule